// File: doc/BRIEF.md
# Scratchpad-Staged Byte Memory Controller

This block is the command layer of a small serial non-volatile memory. It holds a 512-byte array and a 32-byte staging buffer. It works one byte at a time: a link layer hands it each received byte on a strobe, and that strobe also marks a byte that arrived incomplete. The link layer asks for outgoing bytes with a one-cycle request. A transaction reset returns the block to waiting for a command byte.

A host never writes the array directly. First it fills the staging buffer and reads it back, together with the target address and a status byte. Then it repeats that address and status triplet exactly as the authorisation for a copy. The copy then moves the written span into the array and keeps the block busy for a fixed number of clock cycles. A separate command streams the array out from any address.

Top module: `spad_eeprom_ctrl`

## Requirements
- R1: After reset the target address is 0x000 and the status byte is 0x20: ending offset 0, incomplete flag (bit 5) set, accepted flag (bit 7) clear, and bit 6 always 0. A read-buffer command therefore returns 0x00, 0x00, 0x20.
- R2: The first byte after a transaction reset selects the command:
  - 0x0F fills the buffer.
  - 0xAA reads the buffer.
  - 0x55 copies the buffer into the array.
  - 0xF0 reads the array.
  - Any other value makes every later byte ignored, and every read return 0xFF, until the next transaction reset.
- R3: A target address arrives as a low byte and then a high byte. Of the high byte only bit 0 is kept, so the stored address is always within 0x000..0x1FF. The same holds for the address of an array read.
- R4: Buffer-fill data bytes are stored from offset address[4:0] upward. The ending offset (status bits 4:0) becomes the offset of the last byte stored. Data bytes after offset 31 has been filled are ignored.
- R5: The accepted flag is cleared by every 0x0F command. A data byte flagged incomplete during buffer fill is discarded and sets the incomplete flag. A stored full byte clears that flag. An incomplete byte in any other phase has no effect.
- R6: During buffer fill, reads return 0xFF, except when the last stored byte sat at offset 31. In that case the first two reads return the inverted CRC16, low byte first, and later reads return 0xFF. The CRC uses polynomial x^16+x^15+x^2+1, shifted LSB first from zero. It covers the command byte, both address bytes as received and every stored data byte.
- R7: A buffer read returns the address low byte, then the address high byte, then the status byte. It then returns buffer data from offset address[4:0] upward, and 0xFF after offset 31.
- R8: A copy needs three bytes equal to the address low byte, the address high byte and the status byte, in that order. On a match it sets the accepted flag and writes buffer offsets start..ending offset to the array at {address[8:5], offset}.
- R9: A matching copy holds copy_busy high for COPY_CYCLES cycles (at least 32). During that time reads return 0xFF and received bytes are ignored. Once it ends, reads return 0xAA until a transaction reset.
- R10: If any of the three copy bytes differs from the expected byte, the array and the accepted flag stay unchanged. All later reads then return 0xFF until a transaction reset.
- R11: An array read loads the target address, then returns consecutive array bytes on each read and 0xFF after 0x1FF. It leaves the status byte unchanged.
- R12: rd_valid is high in exactly the cycle after each rd_req, with rd_byte valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_rst | input | 1 | Transaction reset: return to command decode |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_partial | input | 1 | The strobed byte was incomplete |
| rd_req | input | 1 | Request for the next outgoing byte |
| rd_valid | output | 1 | Response strobe, one cycle after rd_req |
| rd_byte | output | 8 | Outgoing byte |
| copy_busy | output | 1 | Copy into the array in progress |

## Verification
Buffer fills are tried from three starting points:
- A short fill in mid-page shows that the ending offset and offset-based placement work.
- A full 32-byte fill with a trailing extra byte separates CRC readout from 0xFF and shows the overflow byte is dropped.
- A fill at the top of the array shows address masking and the end-of-array 0xFF.

A correct authorisation triplet and a wrong one are both sent, and the array is read back after each. This tells a real copy apart from an ignored one. Incomplete bytes are sent once inside a fill and once as a command byte, which separates the flagging path from the no-effect path.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam logic [7:0] OP_FILL_BUF = 8'h0F;
  localparam logic [7:0] OP_READ_BUF = 8'hAA;
  localparam logic [7:0] OP_COPY_BUF = 8'h55;
  localparam logic [7:0] OP_READ_MEM = 8'hF0;
  localparam logic [7:0] IDLE_FILL   = 8'hFF;
  localparam logic [7:0] DONE_TOKEN  = 8'hAA;

  typedef enum logic [3:0] {
    ST_CMD, ST_WA_LO, ST_WA_HI, ST_WDATA, ST_RBUF,
    ST_AUTH0, ST_AUTH1, ST_AUTH2, ST_COPY,
    ST_MA_LO, ST_MA_HI, ST_MDATA, ST_DEAD
  } cmd_state_t;

  // one byte through the reflected x^16+x^15+x^2+1 generator
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/spe_crc16.sv
module spe_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import spe_pkg::*;
  always_ff @(posedge clk) begin
    if (rst)       crc <= 16'h0000;
    else if (load) crc <= crc16_step(16'h0000, din);
    else if (en)   crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/spe_ram.sv
module spe_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end
  assign rdata = cells[raddr];
endmodule

// File: rtl/spad_eeprom_ctrl.sv
module spad_eeprom_ctrl #(
  parameter int ADDR_W      = 9,
  parameter int COPY_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txn_rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_partial,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_byte,
  output logic       copy_busy
);
  import spe_pkg::*;

  localparam int PAGE_W = 5;
  localparam int CNT_W  = (COPY_CYCLES > 1) ? $clog2(COPY_CYCLES) : 1;

  cmd_state_t          st_q;
  logic [ADDR_W-1:0]   ta_q;
  logic [PAGE_W-1:0]   eoff_q;
  logic                pf_q, aa_q, full_q;
  logic [PAGE_W:0]     wptr_q, rptr_q;
  logic [1:0]          crc_i_q, hdr_q;
  logic [ADDR_W:0]     mptr_q;
  logic                busy_q, cprun_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [PAGE_W-1:0]   cpoff_q;
  logic                rd_valid_q;
  logic [7:0]          rd_byte_q, rd_mux;

  logic [7:0]  es_byte, ta_hi, auth_exp, spad_q, mem_q;
  logic [15:0] crc_q;
  logic        rx_ok, part_ok, crc_load, crc_en, spad_we, cp_start;

  assign es_byte = {aa_q, 1'b0, pf_q, eoff_q};
  assign ta_hi   = 8'(ta_q >> 8);
  assign rx_ok   = rx_valid && !rx_partial && !busy_q && !txn_rst;
  assign part_ok = rx_valid &&  rx_partial && !busy_q && !txn_rst;

  always_comb begin
    case (st_q)
      ST_AUTH0: auth_exp = ta_q[7:0];
      ST_AUTH1: auth_exp = ta_hi;
      default:  auth_exp = es_byte;
    endcase
  end

  assign crc_load = rx_ok && (st_q == ST_CMD) && (rx_byte == OP_FILL_BUF);
  assign spad_we  = rx_ok && (st_q == ST_WDATA) && !wptr_q[PAGE_W];
  assign crc_en   = spad_we || (rx_ok && (st_q == ST_WA_LO || st_q == ST_WA_HI));
  assign cp_start = rx_ok && (st_q == ST_AUTH2) && (rx_byte == auth_exp);

  spe_crc16 u_crc (
    .clk(clk), .rst(rst), .load(crc_load), .en(crc_en), .din(rx_byte), .crc(crc_q)
  );

  spe_ram #(.AW(PAGE_W), .DW(8)) u_spad (
    .clk(clk), .we(spad_we), .waddr(wptr_q[PAGE_W-1:0]), .wdata(rx_byte),
    .raddr(busy_q ? cpoff_q : rptr_q[PAGE_W-1:0]), .rdata(spad_q)
  );

  spe_ram #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(busy_q && cprun_q), .waddr({ta_q[ADDR_W-1:PAGE_W], cpoff_q}),
    .wdata(spad_q), .raddr(mptr_q[ADDR_W-1:0]), .rdata(mem_q)
  );

  // command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_CMD;  ta_q <= '0;  eoff_q <= '0;  pf_q <= 1'b1;  aa_q <= 1'b0;
      full_q <= 1'b0;  wptr_q <= '0;  rptr_q <= '0;  crc_i_q <= '0;  hdr_q <= '0;
      mptr_q <= '0;
    end else if (txn_rst) begin
      st_q <= ST_CMD;
    end else begin
      case (st_q)
        ST_CMD: if (rx_ok) begin
          case (rx_byte)
            OP_FILL_BUF: begin aa_q <= 1'b0; st_q <= ST_WA_LO; end
            OP_READ_BUF: begin st_q <= ST_RBUF; hdr_q <= '0;
                               rptr_q <= {1'b0, ta_q[PAGE_W-1:0]}; end
            OP_COPY_BUF: st_q <= ST_AUTH0;
            OP_READ_MEM: st_q <= ST_MA_LO;
            default:     st_q <= ST_DEAD;
          endcase
        end
        ST_WA_LO: if (rx_ok) begin ta_q[7:0] <= rx_byte; st_q <= ST_WA_HI; end
        ST_WA_HI: if (rx_ok) begin
          ta_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
          wptr_q  <= {1'b0, ta_q[PAGE_W-1:0]};
          full_q  <= 1'b0;
          crc_i_q <= '0;
          st_q    <= ST_WDATA;
        end
        ST_WDATA: begin
          if (part_ok) pf_q <= 1'b1;
          else if (spad_we) begin
            eoff_q <= wptr_q[PAGE_W-1:0];
            pf_q   <= 1'b0;
            full_q <= &wptr_q[PAGE_W-1:0];
            wptr_q <= wptr_q + 1'b1;
          end
          if (rd_req && full_q && crc_i_q != 2'd2) crc_i_q <= crc_i_q + 1'b1;
        end
        ST_RBUF: if (rd_req) begin
          if (hdr_q != 2'd3)        hdr_q  <= hdr_q + 1'b1;
          else if (!rptr_q[PAGE_W]) rptr_q <= rptr_q + 1'b1;
        end
        ST_AUTH0, ST_AUTH1, ST_AUTH2: if (rx_ok) begin
          if (rx_byte != auth_exp)   st_q <= ST_DEAD;
          else if (st_q == ST_AUTH0) st_q <= ST_AUTH1;
          else if (st_q == ST_AUTH1) st_q <= ST_AUTH2;
          else begin aa_q <= 1'b1; st_q <= ST_COPY; end
        end
        ST_MA_LO: if (rx_ok) begin ta_q[7:0] <= rx_byte; st_q <= ST_MA_HI; end
        ST_MA_HI: if (rx_ok) begin
          ta_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
          mptr_q <= {1'b0, rx_byte[ADDR_W-9:0], ta_q[7:0]};
          st_q   <= ST_MDATA;
        end
        ST_MDATA: if (rd_req && !mptr_q[ADDR_W]) mptr_q <= mptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  // copy engine: one byte per busy cycle, fixed busy length
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; cnt_q <= '0; cprun_q <= 1'b0; cpoff_q <= '0;
    end else if (cp_start) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      cprun_q <= (eoff_q >= ta_q[PAGE_W-1:0]);
      cpoff_q <= ta_q[PAGE_W-1:0];
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(COPY_CYCLES - 1)) busy_q <= 1'b0;
      if (cprun_q) begin
        if (cpoff_q == eoff_q) cprun_q <= 1'b0;
        else                   cpoff_q <= cpoff_q + 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = IDLE_FILL;
    case (st_q)
      ST_WDATA: if (full_q) begin
        if (crc_i_q == 2'd0)      rd_mux = ~crc_q[7:0];
        else if (crc_i_q == 2'd1) rd_mux = ~crc_q[15:8];
      end
      ST_RBUF: begin
        case (hdr_q)
          2'd0:    rd_mux = ta_q[7:0];
          2'd1:    rd_mux = ta_hi;
          2'd2:    rd_mux = es_byte;
          default: rd_mux = rptr_q[PAGE_W] ? IDLE_FILL : spad_q;
        endcase
      end
      ST_COPY:  rd_mux = busy_q ? IDLE_FILL : DONE_TOKEN;
      ST_MDATA: rd_mux = mptr_q[ADDR_W] ? IDLE_FILL : mem_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0; rd_byte_q <= 8'h00;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rd_byte_q <= rd_mux;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_byte   = rd_byte_q;
  assign copy_busy = busy_q;
endmodule

// File: rtl/spe_chk.sv
module spe_chk #(
  parameter int COPY_CYCLES = 40
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_req,
  input logic       rd_valid,
  input logic [7:0] rd_byte,
  input logic       copy_busy,
  input logic [7:0] es
);
  int run_len;
  always_ff @(posedge clk) begin
    if (rst || !copy_busy) run_len <= 0;
    else                   run_len <= run_len + 1;
  end

  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r12_no_unasked_resp: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  a_r9_busy_reads_fill: assert property (@(posedge clk) disable iff (rst)
    (copy_busy && rd_req) |=> (rd_byte == 8'hFF));
  a_r9_busy_status_frozen: assert property (@(posedge clk) disable iff (rst)
    copy_busy |=> $stable(es));
  a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(copy_busy) |-> (run_len == COPY_CYCLES));
  a_r8_accept_flag_on_copy: assert property (@(posedge clk) disable iff (rst)
    $rose(copy_busy) |-> es[7]);
  a_r1_bit6_low: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !es[6]);
endmodule

bind spad_eeprom_ctrl spe_chk #(.COPY_CYCLES(COPY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_byte(rd_byte), .copy_busy(copy_busy), .es(es_byte)
);

// File: tb/spad_eeprom_ctrl_test.sv
module spad_eeprom_ctrl_test;
  localparam int COPY_CYCLES = 40;
  localparam int M_CMD = 0, M_WLO = 1, M_WHI = 2, M_WD = 3, M_RB = 4, M_A0 = 5,
                 M_A1 = 6, M_A2 = 7, M_CP = 8, M_MLO = 9, M_MHI = 10, M_MD = 11, M_DEAD = 12;

  logic clk = 0, rst = 1, txn_rst = 0, rx_valid = 0, rx_partial = 0, rd_req = 0;
  logic [7:0] rx_byte = 0;
  logic rd_valid, copy_busy;
  logic [7:0] rd_byte;
  int checks = 0, errors = 0;
  bit done = 0;

  spad_eeprom_ctrl #(.ADDR_W(9), .COPY_CYCLES(COPY_CYCLES)) uut (
    .clk(clk), .rst(rst), .txn_rst(txn_rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_partial(rx_partial), .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .copy_busy(copy_busy)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [7:0] m_mem [512];
  logic [7:0] m_buf [32];
  int m_st = M_CMD, m_ta = 0, m_eoff = 0, m_pf = 1, m_aa = 0, m_wptr = 0, m_full = 0;
  int m_crc = 0, m_crci = 0, m_ri = 0, m_mp = 0, m_busy = 0;
  int m_auth [3];

  function automatic int crc_feed(int c, int b);
    int r = c;
    for (int k = 0; k < 8; k++) begin
      int fb = (r ^ (b >> k)) & 1;
      r = r >> 1;
      if (fb != 0) r = r ^ 'hA001;
    end
    return r & 'hFFFF;
  endfunction

  function automatic int m_es();
    return (m_aa << 7) | (m_pf << 5) | m_eoff;
  endfunction

  task automatic model_rx(int b, bit part);
    if (m_busy > 0) return;
    if (part) begin
      if (m_st == M_WD) m_pf = 1;
      return;
    end
    case (m_st)
      M_CMD: case (b)
        'h0F: begin m_st = M_WLO; m_aa = 0; m_crc = crc_feed(0, b); end
        'hAA: begin m_st = M_RB; m_ri = 0; end
        'h55: m_st = M_A0;
        'hF0: m_st = M_MLO;
        default: m_st = M_DEAD;
      endcase
      M_WLO: begin m_ta = (m_ta & 'h100) | b; m_crc = crc_feed(m_crc, b); m_st = M_WHI; end
      M_WHI: begin
        m_ta = (m_ta & 'hFF) | ((b & 1) << 8); m_crc = crc_feed(m_crc, b);
        m_wptr = m_ta % 32; m_full = 0; m_crci = 0; m_st = M_WD;
      end
      M_WD: if (m_wptr < 32) begin
        m_buf[m_wptr] = b; m_eoff = m_wptr; m_pf = 0; m_full = (m_wptr == 31);
        m_crc = crc_feed(m_crc, b); m_wptr++;
      end
      M_A0, M_A1, M_A2: begin
        m_auth[0] = m_ta & 'hFF; m_auth[1] = m_ta >> 8; m_auth[2] = m_es();
        if (b != m_auth[m_st - M_A0]) m_st = M_DEAD;
        else if (m_st != M_A2) m_st++;
        else begin
          m_aa = 1; m_st = M_CP; m_busy = COPY_CYCLES;
          for (int o = m_ta % 32; o <= m_eoff; o++) m_mem[(m_ta & 'h1E0) + o] = m_buf[o];
        end
      end
      M_MLO: begin m_ta = (m_ta & 'h100) | b; m_st = M_MHI; end
      M_MHI: begin m_ta = (m_ta & 'hFF) | ((b & 1) << 8); m_mp = m_ta; m_st = M_MD; end
      default: ;
    endcase
  endtask

  function automatic int model_rd();
    int r = 'hFF;
    case (m_st)
      M_WD: if (m_full != 0) begin
        if (m_crci == 0) r = (~m_crc) & 'hFF;
        else if (m_crci == 1) r = ((~m_crc) >> 8) & 'hFF;
        if (m_crci < 2) m_crci++;
      end
      M_RB: begin
        if (m_ri == 0) r = m_ta & 'hFF;
        else if (m_ri == 1) r = m_ta >> 8;
        else if (m_ri == 2) r = m_es();
        else if (m_ri - 3 + m_ta % 32 < 32) r = m_buf[m_ri - 3 + m_ta % 32];
        if (m_ri - 3 + m_ta % 32 < 32) m_ri++;
      end
      M_CP: r = (m_busy > 0) ? 'hFF : 'hAA;
      M_MD: if (m_mp < 512) begin r = m_mem[m_mp]; m_mp++; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-clock comparison of the busy output against the model
  always @(negedge clk) if (!rst && !done) begin
    check(copy_busy === (m_busy > 0), "R9 busy", int'(copy_busy), int'(m_busy > 0));
    if (m_busy > 0) m_busy--;
  end

  task automatic tx(int b, bit part = 0);
    @(negedge clk); rx_valid = 1; rx_byte = 8'(b); rx_partial = part;
    @(posedge clk); #1; rx_valid = 0; rx_partial = 0;
    model_rx(b, part);
  endtask

  task automatic rd(string req);
    int e;
    @(negedge clk); rd_req = 1;
    @(posedge clk); #1; rd_req = 0;
    e = model_rd();
    @(negedge clk);
    check(rd_valid === 1'b1 && rd_byte === 8'(e), req, int'(rd_byte), e);
  endtask

  task automatic txn();
    @(negedge clk); txn_rst = 1;
    @(posedge clk); #1; txn_rst = 0; m_st = M_CMD;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(rd_valid === 1'b0 && copy_busy === 1'b0, "R1 idle outputs", int'(rd_valid), 0);
    // R1 reset header
    tx('hAA); rd("R1 ta lo"); rd("R1 ta hi"); rd("R1 status");
    // R4 mid-page fill, R6 no crc when not full
    txn(); tx('h0F); tx('h26); tx('h00); tx('hA1); tx('hB2); rd("R6 fill read not full");
    txn(); tx('hAA); rd("R7 ta lo"); rd("R7 ta hi"); rd("R4 ending offset"); rd("R7 data0"); rd("R7 data1");
    // R8 matching copy, R9 busy behaviour
    txn(); tx('h55); tx('h26); tx('h00); tx('h07);
    rd("R9 read during busy"); tx('h0F);
    repeat (COPY_CYCLES + 4) @(posedge clk);
    rd("R9 done token"); rd("R9 done token again");
    txn(); tx('hAA); rd("R8 ta lo"); rd("R8 ta hi"); rd("R8 accepted flag");
    txn(); tx('hF0); tx('h26); tx('h00); rd("R8 copied byte0"); rd("R8 copied byte1");
    // R10 wrong authorisation
    txn(); tx('h0F); tx('h26); tx('h00); tx('h11);
    txn(); tx('h55); tx('h26); tx('h00); tx('h07); rd("R10 dead read");
    txn(); tx('hF0); tx('h26); tx('h00); rd("R10 array unchanged");
    txn(); tx('hAA); rd("R10 ta lo"); rd("R10 ta hi"); rd("R10 flag unchanged"); rd("R10 buffer");
    // R3 masked address, full page, R6 crc, R4 overflow ignored
    txn(); tx('h0F); tx('h40); tx('hFE);
    for (int i = 0; i < 32; i++) tx((i * 7 + 3) & 'hFF);
    tx('h55);
    rd("R6 crc lo"); rd("R6 crc hi"); rd("R6 fill after crc");
    txn(); tx('hAA); rd("R3 ta lo"); rd("R3 masked ta hi"); rd("R4 status full page");
    for (int i = 0; i < 32; i++) rd("R7 page data");
    rd("R7 past end");
    txn(); tx('h55); tx('h40); tx('h00); tx('h1F);
    repeat (COPY_CYCLES + 4) @(posedge clk);
    txn(); tx('hF0); tx('h5E); tx('h00); rd("R11 seq byte"); rd("R11 seq byte next");
    // R5 incomplete byte in fill and at command decode
    txn(); tx('h0F); tx('hF0); tx('h01); tx('h12); tx('h34, 1);
    txn(); tx('hAA); rd("R5 ta lo"); rd("R5 ta hi"); rd("R5 incomplete flag"); rd("R5 kept byte");
    txn(); tx('h0F, 1); tx('hAA); rd("R5 partial command ignored");
    // R11 end of array and status untouched
    txn(); tx('h0F); tx('hFE); tx('h01); tx('h5A); tx('hC3);
    txn(); tx('h55); tx('hFE); tx('h01); tx('h1F);
    repeat (COPY_CYCLES + 4) @(posedge clk);
    txn(); tx('hF0); tx('hFE); tx('h03);
    rd("R11 top byte"); rd("R11 last byte"); rd("R11 past end"); rd("R11 past end again");
    txn(); tx('hF0); tx('h40); tx('h00); rd("R11 page start");
    txn(); tx('hAA); rd("R11 ta loaded lo"); rd("R11 ta loaded hi"); rd("R11 status kept");
    // R2 unknown command
    txn(); tx('h33); rd("R2 unknown fill"); tx('hAA); rd("R2 still ignored");
    txn(); tx('hAA); rd("R2 decode restored");
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule